// File: doc/BRIEF.md
# Multi-Channel Wheel Period Meter

This block measures the period of four wheel-speed pulse inputs against one shared, free-running 32-bit timebase. The timebase is a 16-bit low word that advances at the system clock divided by a programmable power of two, with a 16-bit high word that counts low-word wraps. Each input passes through a two-flop synchroniser and an edge detector. A qualifying edge latches the timebase value for that channel. The block then outputs the new value minus the channel's previous latched value, modulo 2^32, with a one-cycle valid pulse.

A capture never resets or reloads the counter. The period is therefore exact however late downstream logic reads it, and all four channels stay on one time scale. When an edge falls in the same cycle as a low-word wrap, the channel latches the already-incremented high word together with a low word of zero, so no captured value mixes an old high word with a new low word. Each channel also has two sticky flags that a host can clear: one that says a capture happened, and one that says a capture came before the host cleared that first flag.

A small write-only register port sets the divider, starts or stops the timebase, picks each channel's edge mode and clears the flags. The first capture after reset, or after a channel leaves the off mode, only loads the reference value.

Top module: `wheel_period_meter`

## Requirements
- R1: All four channels read the same timebase. Channels that see edges with equal spacing report equal periods, whatever the offset between the channels.
- R2: The timebase is never cleared by a capture. `period` is the new capture minus the same channel's previous capture, modulo 2^32, and it changes only while `per_valid` is high.
- R3: Writing register address 0 sets the divide exponent N in bits [2:0] and the timebase run enable in bit 3. The timebase advances once every 2^N clocks, so N=5 divides by 32. After reset N is 0 and the timebase is stopped.
- R4: The high word counts low-word wraps, so a period longer than 65535 ticks comes out exact.
- R5: An edge that coincides with a low-word wrap captures a consistent 32-bit value. A channel seeing an edge on every clock at divide-by-1 reports a period of 1 on every pulse across the wrap.
- R6: Register address 1 holds a 2-bit edge mode per channel, with channel i in bits [2i+1:2i]. The codes are 0 = off, 1 = rising, 2 = falling, 3 = both.
- R7: A channel in the off mode ignores its input. It gives no valid pulse and does not set its capture flag.
- R8: The first capture after reset, or after the channel leaves the off mode, gives no valid pulse. It only sets the reference value and the capture flag.
- R9: Each capture sets the channel's sticky capture flag. Writing 1 to bit i at address 2 clears it, and a capture in the same cycle wins over the clear.
- R10: A capture that arrives while the channel's capture flag is still set sets the channel's sticky overrun flag. Writing 1 to bit 4+i at address 2 clears it.
- R11: After an input change, `per_valid` rises at the third rising clock edge and stays high for exactly one cycle per isolated edge.
- R12: After reset, `per_valid`, `cap_flag`, `ovr_flag` and `period` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 timebase, 1 edge modes, 2 flag clear) |
| cfg_wdata | input | 8 | Register write data |
| wheel_in | input | 4 | Asynchronous wheel pulse inputs |
| period | output | 128 | Per-channel 32-bit period, channel i in bits [32i+31:32i] |
| per_valid | output | 4 | One-cycle pulse per channel when `period` is updated |
| cap_flag | output | 4 | Sticky capture flags |
| ovr_flag | output | 4 | Sticky overrun flags |

## Verification
The bench drives an edge on every clock across the low-word wrap. A design that latched the old high word with the wrapped low word would report one period near 2^32 there instead of 1. A 66000-tick interval catches a design that drops or mis-increments the high word, and divide-by-32 and divide-by-4 intervals catch a wrong prescaler mask. The bench also checks the priming rule and the effect of the off mode, so a design that emits a bogus first period or still captures while off shows extra valid pulses. It checks the overrun and clear sequence, which catches flags that are not sticky or are cleared by the wrong bit.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  localparam logic [1:0] ADDR_TBASE = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_CLEAR = 2'd2;

endpackage

// File: rtl/wpm_cfg.sv
module wpm_cfg
  import wpm_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PS_W = 3,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [PS_W-1:0]   psel,
  output logic              run,
  output logic [2*NCH-1:0]  modes,
  output logic [NCH-1:0]    clr_cap,
  output logic [NCH-1:0]    clr_ovr
);

  logic [PS_W-1:0]  psel_q, psel_d;
  logic             run_q, run_d;
  logic [2*NCH-1:0] mode_q, mode_d;

  always_comb begin
    psel_d = psel_q;
    run_d  = run_q;
    mode_d = mode_q;
    if (cfg_we && cfg_addr == ADDR_TBASE) begin
      psel_d = cfg_wdata[PS_W-1:0];
      run_d  = cfg_wdata[PS_W];
    end
    if (cfg_we && cfg_addr == ADDR_MODE) begin
      mode_d = cfg_wdata[2*NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      run_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      psel_q <= psel_d;
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  assign psel    = psel_q;
  assign run     = run_q;
  assign modes   = mode_q;
  assign clr_cap = (cfg_we && cfg_addr == ADDR_CLEAR) ? cfg_wdata[NCH-1:0]     : '0;
  assign clr_ovr = (cfg_we && cfg_addr == ADDR_CLEAR) ? cfg_wdata[2*NCH-1:NCH] : '0;

endmodule

// File: rtl/wpm_timebase.sv
module wpm_timebase #(
  parameter int LO_W = 16,
  parameter int PS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PS_W-1:0]     psel,
  output logic [2*LO_W-1:0]   ts_next
);

  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [PC_W:0]   one_sh;
  logic [PC_W-1:0] mask;
  logic            tick;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [LO_W-1:0] hi_q, hi_d;

  always_comb begin
    one_sh = (PC_W+1)'(1) << psel;
    mask   = PC_W'(one_sh - 1'b1);
    tick   = ((pcnt_q & mask) == mask);
    pcnt_d = pcnt_q + 1'b1;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (run && tick) begin
      lo_d = lo_q + 1'b1;
      if (&lo_q) hi_d = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  // Captures take the value the count holds after this cycle, so a wrap
  // coinciding with an edge yields the new high word and a zero low word.
  assign ts_next = {hi_d, lo_d};

endmodule

// File: rtl/wpm_chan.sv
module wpm_chan
  import wpm_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] ts,
  input  logic          clr_cap,
  input  logic          clr_ovr,
  output logic [CW-1:0] period,
  output logic          per_valid,
  output logic          cap_flag,
  output logic          ovr_flag
);

  logic          s1_q, s2_q, s3_q;
  logic          rise, fall, hit;
  logic [CW-1:0] last_q, last_d;
  logic [CW-1:0] prd_q, prd_d;
  logic          vld_q, vld_d;
  logic          prm_q, prm_d;
  logic          cap_q, cap_d;
  logic          ovr_q, ovr_d;
  edge_mode_e    emode;

  always_comb begin
    emode = edge_mode_e'(mode);
    rise  = s2_q & ~s3_q;
    fall  = ~s2_q & s3_q;
    case (emode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase

    last_d = last_q;
    prd_d  = prd_q;
    vld_d  = 1'b0;
    prm_d  = prm_q;
    cap_d  = cap_q & ~clr_cap;
    ovr_d  = ovr_q & ~clr_ovr;

    if (emode == EDGE_OFF) begin
      prm_d = 1'b0;
    end else if (hit) begin
      last_d = ts;
      prm_d  = 1'b1;
      cap_d  = 1'b1;
      if (cap_q && !clr_cap) ovr_d = 1'b1;
      if (prm_q) begin
        prd_d = ts - last_q;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      last_q <= '0;
      prd_q  <= '0;
      vld_q  <= 1'b0;
      prm_q  <= 1'b0;
      cap_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      last_q <= last_d;
      prd_q  <= prd_d;
      vld_q  <= vld_d;
      prm_q  <= prm_d;
      cap_q  <= cap_d;
      ovr_q  <= ovr_d;
    end
  end

  assign period    = prd_q;
  assign per_valid = vld_q;
  assign cap_flag  = cap_q;
  assign ovr_flag  = ovr_q;

endmodule

// File: rtl/wheel_period_meter.sv
module wheel_period_meter #(
  parameter  int NCH  = 4,
  parameter  int LO_W = 16,
  parameter  int PS_W = 3,
  localparam int CW   = 2*LO_W,
  localparam int DW   = 2*NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [NCH-1:0]    wheel_in,
  output logic [NCH*CW-1:0] period,
  output logic [NCH-1:0]    per_valid,
  output logic [NCH-1:0]    cap_flag,
  output logic [NCH-1:0]    ovr_flag
);

  logic             rs1_q, rs2_q;
  logic             rst_int_n;
  logic [PS_W-1:0]  psel;
  logic             run;
  logic [2*NCH-1:0] modes;
  logic [NCH-1:0]   clr_cap, clr_ovr;
  logic [CW-1:0]    ts_next;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  wpm_cfg #(.NCH(NCH), .PS_W(PS_W), .DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .psel      (psel),
    .run       (run),
    .modes     (modes),
    .clr_cap   (clr_cap),
    .clr_ovr   (clr_ovr)
  );

  wpm_timebase #(.LO_W(LO_W), .PS_W(PS_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .psel    (psel),
    .ts_next (ts_next)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wpm_chan #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .din       (wheel_in[i]),
      .mode      (modes[2*i +: 2]),
      .ts        (ts_next),
      .clr_cap   (clr_cap[i]),
      .clr_ovr   (clr_ovr[i]),
      .period    (period[i*CW +: CW]),
      .per_valid (per_valid[i]),
      .cap_flag  (cap_flag[i]),
      .ovr_flag  (ovr_flag[i])
    );
  end

endmodule

// File: rtl/wpm_checker.sv
module wpm_checker #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [DW-1:0]     cfg_wdata,
  input logic [NCH*CW-1:0] period,
  input logic [NCH-1:0]    per_valid,
  input logic [NCH-1:0]    cap_flag,
  input logic [NCH-1:0]    ovr_flag
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == 2'd2);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R9: a reported period always comes with the capture flag
    p_flag_on_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      per_valid[i] |-> cap_flag[i]);

    // R9: the capture flag only falls after a clear write to its bit
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag[i] && !(clr_wr && cfg_wdata[i])) |=> cap_flag[i]);

    // R10: overrun can only rise while the capture flag was already set
    p_ovr_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag[i]) |-> $past(cap_flag[i]));

    // R10: the overrun flag only falls after a clear write to its bit
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag[i] && !(clr_wr && cfg_wdata[NCH+i])) |=> ovr_flag[i]);

    // R2: the period output changes only together with a valid pulse
    p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !per_valid[i] |-> $stable(period[i*CW +: CW]));
  end

endmodule

bind wheel_period_meter wpm_checker #(.NCH(NCH), .CW(CW), .DW(DW)) u_wpm_chk (.*);

// File: tb/wheel_period_meter_bench.sv
`timescale 1ns/1ps
module wheel_period_meter_bench;

  localparam int NCH = 4;
  localparam int CW  = 32;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_addr;
  logic [7:0]        cfg_wdata;
  logic [NCH-1:0]    wheel_in;
  logic [NCH*CW-1:0] period;
  logic [NCH-1:0]    per_valid;
  logic [NCH-1:0]    cap_flag;
  logic [NCH-1:0]    ovr_flag;

  int total = 0;
  int bad   = 0;
  int unsigned cyc = 0;
  int vcnt [NCH];
  logic [31:0] lastp [NCH];
  int burst_bad = 0;
  bit burst_on  = 0;

  wheel_period_meter u_wheel_period_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .wheel_in  (wheel_in),
    .period    (period),
    .per_valid (per_valid),
    .cap_flag  (cap_flag),
    .ovr_flag  (ovr_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < NCH; i++) begin
      vcnt[i]  = 0;
      lastp[i] = '0;
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (per_valid[i]) begin
        vcnt[i]  = vcnt[i] + 1;
        lastp[i] = period[i*CW +: CW];
        if (burst_on && i == 0 && period[CW-1:0] != 32'd1) burst_bad = burst_bad + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tgl(input int ch);
    wheel_in[ch] = ~wheel_in[ch];
  endtask

  task automatic do_reset;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; wheel_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
  endtask

  // R12: every output at zero after reset
  task automatic t_reset_state;
    do_reset;
    chk("R12 per_valid", 32'(per_valid), 0);
    chk("R12 cap_flag",  32'(cap_flag), 0);
    chk("R12 ovr_flag",  32'(ovr_flag), 0);
    chk("R12 period",    32'(|period), 0);
  endtask

  // R4 and R5: wrap of the low word and periods beyond 16 bits
  task automatic t_wrap;
    int unsigned start, c1;
    int b0, bb0, v1;
    do_reset;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h07);
    start = cyc;
    idle(100);
    c1 = cyc;
    wheel_in[1] = 1'b1;
    idle(3);
    wheel_in[1] = 1'b0;
    b0 = vcnt[0]; bb0 = burst_bad;
    burst_on = 1;
    while (cyc < start + 65536 - 40) @(negedge clk);
    for (int k = 0; k < 80; k++) begin
      tgl(0);
      @(negedge clk);
    end
    idle(6);
    burst_on = 0;
    chk("R5 pulses across wrap", 32'(vcnt[0] - b0), 79);
    chk("R5 wrong periods across wrap", 32'(burst_bad - bb0), 0);
    v1 = vcnt[1];
    while (cyc != c1 + 66000) @(negedge clk);
    wheel_in[1] = 1'b1;
    idle(4);
    chk("R4 long period count", 32'(vcnt[1] - v1), 1);
    chk("R4 long period", lastp[1], 32'd66000);
    wheel_in[1] = 1'b0;
    idle(4);
  endtask

  // R11: latency and single-cycle pulse
  task automatic t_latency;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'hFF);
    tgl(0);
    idle(6);
    tgl(0);
    idle(2);
    chk("R11 valid low before third edge", 32'(per_valid[0]), 0);
    idle(1);
    chk("R11 valid at third edge", 32'(per_valid[0]), 1);
    chk("R11 period value", period[CW-1:0], 32'd6);
    idle(1);
    chk("R11 one cycle pulse", 32'(per_valid[0]), 0);
  endtask

  // R1 and R2: two channels, equal spacing, different offsets
  task automatic t_shared;
    for (int r = 0; r < 3; r++) begin
      tgl(0);
      idle(13);
      tgl(1);
      idle(44);
    end
    idle(6);
    chk("R1 channel 0 period", lastp[0], 32'd57);
    chk("R2 channel 1 period", lastp[1], 32'd57);
  endtask

  // R3: prescaler by 32 and by 4
  task automatic t_prescale;
    wr(2'd0, 8'h0D);
    for (int r = 0; r < 3; r++) begin
      tgl(2);
      idle(320);
    end
    chk("R3 divide by 32", lastp[2], 32'd10);
    wr(2'd0, 8'h0A);
    for (int r = 0; r < 3; r++) begin
      tgl(2);
      idle(40);
    end
    chk("R3 divide by 4", lastp[2], 32'd10);
    if (wheel_in[2]) begin
      tgl(2);
      idle(6);
    end
  endtask

  // R6, R7 and R8: per-channel modes
  task automatic t_modes;
    int b [NCH];
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h00);
    wheel_in = '0;
    idle(5);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hC9);
    for (int i = 0; i < NCH; i++) b[i] = vcnt[i];
    wheel_in = '1;
    idle(6);
    chk("R8 first rise no valid", 32'(vcnt[0] - b[0]), 0);
    chk("R8 first rise sets flag", 32'(cap_flag[0]), 1);
    idle(4);
    wheel_in = '0;
    idle(20);
    wheel_in = '1;
    idle(20);
    wheel_in = '0;
    idle(8);
    chk("R6 rising count", 32'(vcnt[0] - b[0]), 1);
    chk("R6 rising period", lastp[0], 32'd30);
    chk("R6 falling count", 32'(vcnt[1] - b[1]), 1);
    chk("R6 falling period", lastp[1], 32'd40);
    chk("R6 both count", 32'(vcnt[3] - b[3]), 3);
    chk("R6 both period", lastp[3], 32'd20);
    chk("R7 off no valid", 32'(vcnt[2] - b[2]), 0);
    chk("R7 off no flag", 32'(cap_flag[2]), 0);
  endtask

  // R8: leaving the off mode re-primes
  task automatic t_reprime;
    int b0;
    wr(2'd1, 8'hFF);
    tgl(0);
    idle(10);
    wr(2'd1, 8'hFC);
    wr(2'd1, 8'hFF);
    b0 = vcnt[0];
    tgl(0);
    idle(9);
    chk("R8 re-enable first edge", 32'(vcnt[0] - b0), 0);
    tgl(0);
    idle(6);
    chk("R8 re-enable second edge", 32'(vcnt[0] - b0), 1);
    chk("R8 re-enable period", lastp[0], 32'd9);
  endtask

  // R9 and R10: sticky flags and clears
  task automatic t_flags;
    wr(2'd2, 8'hFF);
    idle(2);
    chk("R9 cleared", 32'(cap_flag[3]), 0);
    tgl(3);
    idle(5);
    chk("R9 set on capture", 32'(cap_flag[3]), 1);
    chk("R10 no overrun yet", 32'(ovr_flag[3]), 0);
    tgl(3);
    idle(5);
    chk("R10 overrun set", 32'(ovr_flag[3]), 1);
    wr(2'd2, 8'h08);
    idle(1);
    chk("R9 clear capture flag", 32'(cap_flag[3]), 0);
    chk("R10 overrun kept", 32'(ovr_flag[3]), 1);
    wr(2'd2, 8'h80);
    idle(1);
    chk("R10 overrun cleared", 32'(ovr_flag[3]), 0);
  endtask

  initial begin
    t_reset_state;
    t_wrap;
    t_latency;
    t_shared;
    t_prescale;
    t_modes;
    t_reprime;
    t_flags;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule